// File: doc/BRIEF.md
# Battery Voltage Supervisor

This block decides, from a node's supply voltage, when the node should report a weak battery and when it must power itself down. An external converter samples the divided battery voltage at scheduled moments and hands the block a 10-bit result with a one-cycle strobe. The block keeps only the top eight bits of that result. The dropped low bits act as a cheap filter against conversion noise. A code `c` stands for roughly `c * VREF / 256`, so the code range covers ground up to one LSB below VREF.

Two programmable 8-bit threshold codes split the range into three bands: normal, warning and critical. The critical code is set below the warning code. On the first sample inside the warning band, the block emits a single warning pulse. On a sample in the critical band, it emits a single critical pulse. On the following cycle it raises a shutdown request that holds until reset, whatever the battery does afterwards, so a recovering cell cannot toggle the node on and off. The check is active only when a software enable input is high and the battery-sense circuit was found present when reset was applied.

Top module: `bvs_supervisor`

## Requirements
- R1: Only bits [9:2] of `adc_raw` form the 8-bit code. Bits [1:0] have no effect on which band a sample falls in.
- R2: A sample is in the warning band when its code is strictly less than the warning threshold and not less than the critical threshold. A code equal to the warning threshold counts as normal.
- R3: On an accepted sample, `warn_evt` pulses high for one cycle, starting the cycle after the strobe, only when the block moves from normal into the warning band. Further warning-band samples give no pulse.
- R4: An accepted sample whose code is at or above the warning threshold re-arms the warning, so the next warning-band sample pulses `warn_evt` again.
- R5: An accepted sample whose code is strictly below the critical threshold pulses `crit_evt` for one cycle, starting the cycle after the strobe. `shutdown_req` rises in the cycle after that pulse. A code equal to the critical threshold is not critical. `warn_evt` and `crit_evt` are never high together.
- R6: Once `shutdown_req` is high, it stays high until reset, and every sample strobe is ignored, so neither event pulses again.
- R7: A sample strobe with `check_en` low is ignored, and the band state stays as it was.
- R8: `sense_present` is captured while `rst` is high. If it was captured low, no sample is ever accepted until the next reset, whatever the pin does afterwards.
- R9: Reset loads the thresholds with `WARN_CODE_DEF` (150) and `CRIT_CODE_DEF` (130). A cycle with `thr_wr` high loads `thr_warn` and `thr_crit`, and later samples are judged against the new values.
- R10: While and just after reset, `warn_evt`, `crit_evt` and `shutdown_req` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_present | input | 1 | Battery-sense circuit detected; captured during reset |
| check_en | input | 1 | Low-battery checking enabled |
| sample_valid | input | 1 | One-cycle strobe marking a new conversion result |
| adc_raw | input | 10 | Raw conversion result |
| thr_wr | input | 1 | Load both threshold registers |
| thr_warn | input | 8 | New warning threshold code |
| thr_crit | input | 8 | New critical threshold code |
| warn_evt | output | 1 | One-cycle warning event |
| crit_evt | output | 1 | One-cycle critical event |
| shutdown_req | output | 1 | Latched request to shut the node down |

## Verification
The bench presents codes equal to each threshold and one below it, with the low raw bits set. A design that compared with less-or-equal, or that used the low bits, would warn or go critical one code early. It sends repeated warning-band samples, plus one sample with checking disabled that would otherwise re-arm. A design without the one-shot rule, or one that honoured a disabled sample, would pulse the warning again. After the critical event it sends high and low samples. A design that dropped the latch, or that kept listening, would release the shutdown or emit fresh events. It also resets with the sense flag low and raises the pin afterwards, which catches a design that reads the pin live instead of capturing it.

// File: rtl/bvs_pkg.sv
package bvs_pkg;

    localparam int ADC_W  = 10;
    localparam int CODE_W = 8;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t warn;
        code_t crit;
    } thresh_t;

    typedef enum logic [1:0] {
        BAND_OK   = 2'd0,
        BAND_WARN = 2'd1,
        BAND_CRIT = 2'd2
    } band_e;

    typedef enum logic [1:0] {
        ST_ARMED  = 2'd0,
        ST_WARNED = 2'd1,
        ST_CRIT   = 2'd2,
        ST_OFF    = 2'd3
    } sup_state_e;

    // keep the upper CODE_W bits of the conversion result
    function automatic code_t to_code(input logic [ADC_W-1:0] raw);
        return raw[ADC_W-1 -: CODE_W];
    endfunction

    function automatic band_e classify(input code_t code, input thresh_t thr);
        if (code < thr.crit)
            return BAND_CRIT;
        else if (code < thr.warn)
            return BAND_WARN;
        else
            return BAND_OK;
    endfunction

endpackage

// File: rtl/bvs_cfg_regs.sv
module bvs_cfg_regs
    import bvs_pkg::*;
#(
    parameter code_t WARN_DEF = 8'd150,
    parameter code_t CRIT_DEF = 8'd130
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sense_present,
    input  logic    thr_wr,
    input  code_t   thr_warn,
    input  code_t   thr_crit,
    output thresh_t thr,
    output logic    present_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr.warn  <= WARN_DEF;
            thr.crit  <= CRIT_DEF;
            present_q <= sense_present;   // R8: captured only during reset
        end else if (thr_wr) begin
            thr.warn  <= thr_warn;
            thr.crit  <= thr_crit;
        end
    end

endmodule

// File: rtl/bvs_band_classifier.sv
module bvs_band_classifier
    import bvs_pkg::*;
(
    input  logic [ADC_W-1:0] adc_raw,
    input  thresh_t          thr,
    output band_e            band
);

    code_t code;

    always_comb begin
        code = to_code(adc_raw);
        band = classify(code, thr);
    end

endmodule

// File: rtl/bvs_policy_fsm.sv
module bvs_policy_fsm
    import bvs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sample_valid,
    input  logic  check_en,
    input  logic  present_q,
    input  band_e band,
    output logic  warn_evt,
    output logic  crit_evt,
    output logic  shutdown_req
);

    sup_state_e state;
    logic       take;

    assign take = sample_valid & check_en & present_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_ARMED;
            warn_evt     <= 1'b0;
            crit_evt     <= 1'b0;
            shutdown_req <= 1'b0;
        end else begin
            warn_evt <= 1'b0;
            crit_evt <= 1'b0;
            case (state)
                ST_ARMED, ST_WARNED: begin
                    if (take) begin
                        case (band)
                            BAND_CRIT: begin
                                crit_evt <= 1'b1;
                                state    <= ST_CRIT;
                            end
                            BAND_WARN: begin
                                if (state == ST_ARMED)
                                    warn_evt <= 1'b1;
                                state <= ST_WARNED;
                            end
                            default: state <= ST_ARMED;
                        endcase
                    end
                end
                ST_CRIT: begin
                    state        <= ST_OFF;
                    shutdown_req <= 1'b1;
                end
                default: begin
                    shutdown_req <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/bvs_supervisor.sv
module bvs_supervisor
    import bvs_pkg::*;
#(
    parameter code_t WARN_CODE_DEF = 8'd150,
    parameter code_t CRIT_CODE_DEF = 8'd130
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sense_present,
    input  logic             check_en,
    input  logic             sample_valid,
    input  logic [ADC_W-1:0] adc_raw,
    input  logic             thr_wr,
    input  logic [CODE_W-1:0] thr_warn,
    input  logic [CODE_W-1:0] thr_crit,
    output logic             warn_evt,
    output logic             crit_evt,
    output logic             shutdown_req
);

    thresh_t thr;
    logic    present_q;
    band_e   band;

    bvs_cfg_regs #(
        .WARN_DEF (WARN_CODE_DEF),
        .CRIT_DEF (CRIT_CODE_DEF)
    ) u_cfg (
        .clk           (clk),
        .rst           (rst),
        .sense_present (sense_present),
        .thr_wr        (thr_wr),
        .thr_warn      (thr_warn),
        .thr_crit      (thr_crit),
        .thr           (thr),
        .present_q     (present_q)
    );

    bvs_band_classifier u_cls (
        .adc_raw (adc_raw),
        .thr     (thr),
        .band    (band)
    );

    bvs_policy_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .check_en     (check_en),
        .present_q    (present_q),
        .band         (band),
        .warn_evt     (warn_evt),
        .crit_evt     (crit_evt),
        .shutdown_req (shutdown_req)
    );

endmodule

// File: rtl/bvs_supervisor_chk.sv
module bvs_supervisor_chk (
    input logic clk,
    input logic rst,
    input logic sample_valid,
    input logic check_en,
    input logic warn_evt,
    input logic crit_evt,
    input logic shutdown_req
);

    assert_evt_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(warn_evt && crit_evt));

    assert_crit_then_shut_R5: assert property (@(posedge clk) disable iff (rst)
        crit_evt |=> shutdown_req);

    assert_shut_only_after_crit_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown_req) |-> $past(crit_evt));

    assert_shut_latched_R6: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |=> shutdown_req);

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> (!warn_evt && !crit_evt));

    assert_warn_single_R3: assert property (@(posedge clk) disable iff (rst)
        warn_evt |=> !warn_evt);

    assert_evt_needs_enabled_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (warn_evt || crit_evt) |-> $past(sample_valid && check_en));

endmodule

bind bvs_supervisor bvs_supervisor_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .check_en     (check_en),
    .warn_evt     (warn_evt),
    .crit_evt     (crit_evt),
    .shutdown_req (shutdown_req)
);

// File: tb/bvs_supervisor_test.sv
module bvs_supervisor_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sense_present = 1'b1;
    logic       check_en = 1'b0;
    logic       sample_valid = 1'b0;
    logic [9:0] adc_raw = '0;
    logic       thr_wr = 1'b0;
    logic [7:0] thr_warn = '0;
    logic [7:0] thr_crit = '0;
    logic       warn_evt, crit_evt, shutdown_req;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bvs_supervisor uut (
        .clk           (clk),
        .rst           (rst),
        .sense_present (sense_present),
        .check_en      (check_en),
        .sample_valid  (sample_valid),
        .adc_raw       (adc_raw),
        .thr_wr        (thr_wr),
        .thr_warn      (thr_warn),
        .thr_crit      (thr_crit),
        .warn_evt      (warn_evt),
        .crit_evt      (crit_evt),
        .shutdown_req  (shutdown_req)
    );

    // entry: {enable, raw[9:0], expected warn, expected crit}
    localparam int NVEC = 9;
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 10'd603, 1'b0, 1'b0},  // R1 R2: code 150 with low bits set, normal
        {1'b1, 10'd599, 1'b1, 1'b0},  // R1 R2: code 149, enters warning band
        {1'b1, 10'd560, 1'b0, 1'b0},  // R3: still in band, no repeat
        {1'b1, 10'd596, 1'b0, 1'b0},  // R3: still in band, no repeat
        {1'b0, 10'd800, 1'b0, 1'b0},  // R7: disabled, would re-arm
        {1'b1, 10'd580, 1'b0, 1'b0},  // R7: not re-armed, so no pulse
        {1'b1, 10'd600, 1'b0, 1'b0},  // R4: code 150 re-arms
        {1'b1, 10'd592, 1'b1, 1'b0},  // R4: pulse again
        {1'b1, 10'd520, 1'b0, 1'b0}   // R5: code equal to critical is not critical
    };

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic present);
        @(negedge clk);
        rst = 1'b1;
        sense_present = present;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic sample(input logic en, input logic [9:0] raw,
                          input logic ew, input logic ec, input logic es,
                          input string tag);
        @(negedge clk);
        check_en = en;
        adc_raw = raw;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        check({tag, " warn_evt"}, warn_evt, ew);
        check({tag, " crit_evt"}, crit_evt, ec);
        check({tag, " shutdown_req"}, shutdown_req, es);
    endtask

    task automatic write_thr(input logic [7:0] w, input logic [7:0] c);
        @(negedge clk);
        thr_wr = 1'b1;
        thr_warn = w;
        thr_crit = c;
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset state
        @(negedge clk);
        @(negedge clk);
        check("R10 warn_evt in reset", warn_evt, 1'b0);
        check("R10 crit_evt in reset", crit_evt, 1'b0);
        check("R10 shutdown_req in reset", shutdown_req, 1'b0);
        do_reset(1'b1);
        check("R10 shutdown_req after reset", shutdown_req, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            sample(VEC[i][12], VEC[i][11:2], VEC[i][1], VEC[i][0], 1'b0,
                   $sformatf("vector %0d", i));
        end

        // R5: code 129 is critical, then shutdown one cycle later
        sample(1'b1, 10'd519, 1'b0, 1'b1, 1'b0, "R5 critical");
        @(negedge clk);
        check("R5 crit_evt single", crit_evt, 1'b0);
        check("R5 shutdown_req raised", shutdown_req, 1'b1);

        // R6: latched, samples ignored
        sample(1'b1, 10'd1020, 1'b0, 1'b0, 1'b1, "R6 high sample");
        sample(1'b1, 10'd0,    1'b0, 1'b0, 1'b1, "R6 low sample");
        repeat (3) @(negedge clk);
        check("R6 still latched", shutdown_req, 1'b1);

        // R8: sense absent at reset
        do_reset(1'b0);
        check("R10 shutdown cleared by reset", shutdown_req, 1'b0);
        sample(1'b1, 10'd0, 1'b0, 1'b0, 1'b0, "R8 absent");
        @(negedge clk);
        sense_present = 1'b1;
        sample(1'b1, 10'd4, 1'b0, 1'b0, 1'b0, "R8 pin raised late");
        @(negedge clk);
        check("R8 no shutdown", shutdown_req, 1'b0);

        // R9: programmed thresholds
        do_reset(1'b1);
        write_thr(8'd100, 8'd50);
        sample(1'b1, 10'd480, 1'b0, 1'b0, 1'b0, "R9 code 120 normal");
        sample(1'b1, 10'd399, 1'b1, 1'b0, 1'b0, "R9 code 99 warns");
        sample(1'b1, 10'd203, 1'b0, 1'b0, 1'b0, "R9 code 50 not critical");
        sample(1'b1, 10'd196, 1'b0, 1'b1, 1'b0, "R9 code 49 critical");
        @(negedge clk);
        check("R9 shutdown after crit", shutdown_req, 1'b1);

        // R9: reset restores defaults
        do_reset(1'b1);
        sample(1'b1, 10'd596, 1'b1, 1'b0, 1'b0, "R9 default warn 150");

        // R5: direct fall to critical from normal gives no warning
        do_reset(1'b1);
        sample(1'b1, 10'd100, 1'b0, 1'b1, 1'b0, "R5 direct critical");
        @(negedge clk);
        check("R5 direct shutdown", shutdown_req, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule